// File: doc/BRIEF.md
# SONET/SDH byte aligner and frame finder

This block sits behind a clock-and-data recovery stage. It takes a bit-serial SONET/SDH line stream, sampled on the recovered bit clock, and turns it into byte-wide parallel data. It also produces a byte clock that runs at one eighth of the bit rate. A 48-bit sliding comparator watches for the framing word: three A1 bytes (8'hF6) followed at once by three A2 bytes (8'h28). Whenever that word sits on the current byte boundaries, a one-byte sync pulse is raised.

The byte boundary (the rotation) moves only through a hunt. A rising edge on the out-of-frame input arms the hunt. The first place in the bit stream where the framing word ends then becomes the new boundary, and the rotation is frozen there until the next rising edge. A disable input blocks all hunting. A second divided clock, the byte clock divided by 3 or by 12, is provided as a reference for downstream timing.

Top module: `sonet_byte_framer`

## Requirements
- R1: While `rst` is high, every divider, counter and the alignment state are cleared. `byte_clk` and `ref_clk` read 1, and `par_out` and `sync_out` read 0.
- R2: `byte_clk` is high for 4 bit-clock cycles and then low for 4. Its first fall comes at the 4th bit-clock edge after reset is released.
- R3: `par_out` changes only at the bit-clock edge where `byte_clk` falls. It then holds the 8 most recent complete bits on the current boundary, with the first-received bit in bit 7 and the last-received bit in bit 0. After reset, bytes end on serial bit numbers 3 mod 8, counting the first bit sampled after reset as bit 1.
- R4: `sync_out` is updated together with `par_out` and is high for exactly one byte period. It goes high when the 48 bits ending with the byte just presented equal F6 F6 F6 28 28 28, whatever the level of `oof_in`.
- R5: After a 0-to-1 transition of `oof_in` while `recov_dis` is low, the block searches every bit position. At the first full match it moves the boundary so that the last A2 byte ends a byte, and it raises `sync_out` for that frame. This also holds when the match ends exactly on the old boundary.
- R6: Once a match has set the boundary, framing words at any other bit offset neither move the boundary nor raise `sync_out`.
- R7: Holding `oof_in` high does not start a new search. Only a new rising edge does.
- R8: While `recov_dis` is high, an `oof_in` rising edge leaves the boundary unchanged, and no search continues after `recov_dis` falls.
- R9: `ref_clk` divides the byte clock. With `rate_sel` = 0 it repeats every 3 byte periods and is high for the first 1. With `rate_sel` = 1 it repeats every 12 byte periods and is high for the first 6. It changes only where `byte_clk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Recovered serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial line data, first bit of each byte is its MSB |
| oof_in | input | 1 | Out-of-frame indication; its rising edge arms a search |
| recov_dis | input | 1 | Blocks frame search while high |
| rate_sel | input | 1 | Reference divider: 0 = divide by 3, 1 = divide by 12 |
| byte_clk | output | 1 | Bit clock divided by 8 |
| ref_clk | output | 1 | Byte clock divided by 3 or 12 |
| par_out | output | 8 | Aligned parallel byte, bit 0 least significant |
| sync_out | output | 1 | One-byte pulse on each aligned framing word |

## Verification
The assertions assume that `rate_sel` changes only while `rst` is high. A change at any other time would move `ref_clk` off a byte-clock rising edge. The bench therefore switches the rate only inside a reset. The hunt checks also assume that no stray 48-bit framing word appears in the payload between an out-of-frame edge and the intended pattern. The stimulus fills the padding with seeded random bits, so such a word is vanishingly unlikely, and it places every framing word at a bit offset chosen by the bench.

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer #(
  parameter int BYTE_W   = 8,
  parameter int PAT_LEN  = 3,
  parameter logic [BYTE_W-1:0] A1_BYTE = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_BYTE = 8'h28,
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 12
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              oof_in,
  input  logic              recov_dis,
  input  logic              rate_sel,
  output logic              byte_clk,
  output logic              ref_clk,
  output logic [BYTE_W-1:0] par_out,
  output logic              sync_out
);

  localparam int WIN_W = 2 * PAT_LEN * BYTE_W;
  localparam int SR_W  = WIN_W + BYTE_W - 1;
  localparam int PH_W  = $clog2(BYTE_W);
  localparam int HALF  = BYTE_W / 2;
  localparam int REF_W = $clog2(DIV_SLOW + 1);
  localparam logic [WIN_W-1:0] PATTERN = {{PAT_LEN{A1_BYTE}}, {PAT_LEN{A2_BYTE}}};

  logic [SR_W-1:0]  sr;
  logic [PH_W-1:0]  phase, rot, rot_eff;
  logic [REF_W-1:0] refcnt, div_n;
  logic             hunt, oof_q, raw_hit, lock_hit, boundary;

  assign boundary = (phase == PH_W'(HALF - 1));
  assign raw_hit  = (sr[WIN_W-1:0] == PATTERN);
  assign lock_hit = hunt & raw_hit & ~recov_dis;
  assign rot_eff  = lock_hit ? PH_W'(HALF - 1) - phase : rot;
  assign byte_clk = (phase < PH_W'(HALF));
  assign div_n    = rate_sel ? REF_W'(DIV_SLOW) : REF_W'(DIV_FAST);
  assign ref_clk  = (refcnt < (div_n >> 1));

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      sr       <= '0;
      phase    <= '0;
      rot      <= '0;
      hunt     <= 1'b0;
      oof_q    <= 1'b1;
      refcnt   <= '0;
      par_out  <= '0;
      sync_out <= 1'b0;
    end else begin
      sr    <= {sr[SR_W-2:0], ser_in};
      phase <= phase + PH_W'(1);
      oof_q <= oof_in;

      if (recov_dis)            hunt <= 1'b0;
      else if (oof_in & ~oof_q) hunt <= 1'b1;
      else if (lock_hit)        hunt <= 1'b0;

      if (lock_hit) rot <= rot_eff;

      if (boundary) begin
        par_out  <= sr[rot_eff +: BYTE_W];
        sync_out <= (sr[rot_eff +: WIN_W] == PATTERN);
      end

      if (phase == '1)
        refcnt <= (refcnt >= div_n - REF_W'(1)) ? '0 : refcnt + REF_W'(1);
    end
  end

endmodule

// File: rtl/sonet_byte_framer_chk.sv
module sonet_byte_framer_chk #(
  parameter int BYTE_W = 8,
  parameter int PH_W   = 3
) (
  input logic              bit_clk,
  input logic              rst,
  input logic              byte_clk,
  input logic              ref_clk,
  input logic              sync_out,
  input logic [BYTE_W-1:0] par_out,
  input logic              recov_dis,
  input logic              hunt,
  input logic [PH_W-1:0]   rot
);

  localparam int HALF = BYTE_W / 2;

  logic       bc_q;
  logic [7:0] run;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      bc_q <= 1'b1;
      run  <= '0;
    end else begin
      bc_q <= byte_clk;
      run  <= (byte_clk != bc_q) ? 8'd1 : run + 8'd1;
    end
  end

  p_byte_half_r2: assert property (@(posedge bit_clk) disable iff (rst)
    (byte_clk != bc_q) |-> (run == 8'(HALF)));

  p_par_hold_r3: assert property (@(posedge bit_clk) disable iff (rst)
    !$fell(byte_clk) |-> $stable(par_out));

  p_sync_hold_r4: assert property (@(posedge bit_clk) disable iff (rst)
    !$fell(byte_clk) |-> $stable(sync_out));

  p_sync_single_r4: assert property (@(posedge bit_clk) disable iff (rst)
    ($fell(byte_clk) && $past(sync_out)) |-> !sync_out);

  p_rot_frozen_r6: assert property (@(posedge bit_clk) disable iff (rst)
    !hunt |=> $stable(rot));

  p_dis_idle_r8: assert property (@(posedge bit_clk) disable iff (rst)
    recov_dis |=> !hunt);

  p_ref_step_r9: assert property (@(posedge bit_clk) disable iff (rst)
    !$stable(ref_clk) |-> $rose(byte_clk));

endmodule

bind sonet_byte_framer sonet_byte_framer_chk #(.BYTE_W(BYTE_W), .PH_W(PH_W)) u_chk (
  .bit_clk  (bit_clk),
  .rst      (rst),
  .byte_clk (byte_clk),
  .ref_clk  (ref_clk),
  .sync_out (sync_out),
  .par_out  (par_out),
  .recov_dis(recov_dis),
  .hunt     (hunt),
  .rot      (rot)
);

// File: tb/sim_sonet_byte_framer.sv
`timescale 1ns/1ps
module sim_sonet_byte_framer;

  localparam logic [47:0] PAT = 48'hF6F6F6282828;

  logic bit_clk = 1'b0;
  logic rst = 1'b1, ser_in = 1'b0, oof_in = 1'b0, recov_dis = 1'b0, rate_sel = 1'b0;
  logic byte_clk, ref_clk, sync_out;
  logic [7:0] par_out;

  int checks = 0, errors = 0, n = 0;
  int cur_align = 3, pend_align = 0, pend_edge = 0, div_now = 3, sync_rises = 0;
  bit pend_valid = 0, done = 0, prev_sync = 0;
  bit bits [0:8191];
  logic [7:0] exp_par = '0;
  logic exp_sync = 1'b0;

  always #2.5 bit_clk = ~bit_clk;

  sonet_byte_framer u0 (
    .bit_clk(bit_clk), .rst(rst), .ser_in(ser_in), .oof_in(oof_in),
    .recov_dis(recov_dis), .rate_sel(rate_sel), .byte_clk(byte_clk),
    .ref_clk(ref_clk), .par_out(par_out), .sync_out(sync_out)
  );

  function automatic bit gb(int i);
    return (i < 1) ? 1'b0 : bits[i];
  endfunction

  function automatic logic [7:0] byte_at(int j);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = gb(j - 7 + k);
    return r;
  endfunction

  function automatic bit frame_at(int j);
    logic [47:0] w;
    for (int k = 0; k < 48; k++) w[47-k] = gb(j - 47 + k);
    return (w == PAT);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit b);
    int j;
    ser_in = b;
    @(posedge bit_clk);
    n++;
    bits[n] = b;
    @(negedge bit_clk);
    chk(byte_clk == ((n % 8) < 4), "R2", "byte_clk", byte_clk, ((n % 8) < 4));
    chk(ref_clk == (((n / 8) % div_now) < div_now / 2), "R9", "ref_clk", ref_clk,
        (((n / 8) % div_now) < div_now / 2));
    if (n % 8 == 4) begin
      if (pend_valid && n >= pend_edge) begin
        cur_align  = pend_align;
        pend_valid = 0;
      end
      j = n - 1 - ((((n - 1 - cur_align) % 8) + 8) % 8);
      exp_par  = byte_at(j);
      exp_sync = frame_at(j);
    end
    chk(par_out == exp_par, "R3", "par_out", par_out, exp_par);
    chk(sync_out == exp_sync, "R4", "sync_out", sync_out, exp_sync);
    if (sync_out && !prev_sync) sync_rises++;
    prev_sync = sync_out;
  endtask

  task automatic rand_bits(input int cnt);
    for (int i = 0; i < cnt; i++) tick(1'($urandom));
  endtask

  task automatic send_frame(input int align, input bit expect_lock);
    while (((n + 48) % 8) != align) tick(1'($urandom));
    if (expect_lock) begin
      pend_align = align;
      pend_edge  = n + 49;
      pend_valid = 1;
    end
    for (int i = 47; i >= 0; i--) tick(PAT[i]);
    rand_bits(24);
  endtask

  task automatic oof_rise();
    oof_in = 1'b0;
    tick(1'($urandom));
    oof_in = 1'b1;
    tick(1'($urandom));
  endtask

  task automatic do_reset(input bit rate);
    rst = 1'b1;
    rate_sel = rate;
    div_now = rate ? 12 : 3;
    oof_in = 1'b0;
    recov_dis = 1'b0;
    repeat (3) @(posedge bit_clk);
    @(negedge bit_clk);
    chk(byte_clk == 1'b1, "R1", "byte_clk in reset", byte_clk, 1);
    chk(ref_clk == 1'b1, "R1", "ref_clk in reset", ref_clk, 1);
    chk(par_out == 8'h00, "R1", "par_out in reset", par_out, 0);
    chk(sync_out == 1'b0, "R1", "sync_out in reset", sync_out, 0);
    foreach (bits[i]) bits[i] = 1'b0;
    n = 0; cur_align = 3; pend_valid = 0;
    exp_par = '0; exp_sync = 1'b0; prev_sync = 0;
    rst = 1'b0;
  endtask

  initial begin
    int r0, a;
    r0 = $urandom(32'd8101);
    do_reset(1'b0);

    for (int i = 0; i < 5; i++) begin
      for (int b = 7; b >= 0; b--) tick(r0[b]);
      r0 = $urandom;
    end
    rand_bits(20);

    r0 = sync_rises;
    send_frame(3, 0);
    chk(sync_rises == r0 + 1, "R4", "sync on default boundary", sync_rises - r0, 1);

    oof_rise();
    rand_bits(13);
    r0 = sync_rises;
    send_frame(6, 1);
    chk(sync_rises == r0 + 1, "R5", "lock at offset 6", sync_rises - r0, 1);

    r0 = sync_rises;
    send_frame(1, 0);
    chk(sync_rises == r0, "R7", "held oof level no new search", sync_rises - r0, 0);
    send_frame(6, 0);
    chk(sync_rises == r0 + 1, "R4", "sync with oof high", sync_rises - r0, 1);

    oof_in = 1'b0;
    r0 = sync_rises;
    send_frame(5, 0);
    chk(sync_rises == r0, "R6", "offset 5 after lock ignored", sync_rises - r0, 0);

    recov_dis = 1'b1;
    oof_rise();
    r0 = sync_rises;
    send_frame(2, 0);
    chk(sync_rises == r0, "R8", "disabled search", sync_rises - r0, 0);
    recov_dis = 1'b0;
    send_frame(2, 0);
    chk(sync_rises == r0, "R8", "no search after enable", sync_rises - r0, 0);
    oof_in = 1'b0;

    oof_rise();
    r0 = sync_rises;
    send_frame(3, 1);
    chk(sync_rises == r0 + 1, "R5", "match on old boundary", sync_rises - r0, 1);

    for (int it = 0; it < 8; it++) begin
      a = int'($urandom % 8);
      oof_rise();
      rand_bits(int'($urandom % 21));
      r0 = sync_rises;
      send_frame(a, 1);
      chk(sync_rises == r0 + 1, "R5", "random offset lock", sync_rises - r0, 1);
      oof_in = 1'b0;
      rand_bits(int'($urandom % 30));
    end

    do_reset(1'b1);
    rand_bits(200);
    r0 = sync_rises;
    send_frame(3, 0);
    chk(sync_rises == r0 + 1, "R4", "sync at slow rate", sync_rises - r0, 1);
    rand_bits(200);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule